// File: doc/BRIEF.md
# Dual Phase-Correct PWM Generator

This block produces two pulse-width-modulated outputs from one shared up/down counter. The counter climbs one step per enabled tick from zero to a ceiling set by the chosen resolution (8, 9 or 10 bits). It then turns and descends to zero, and the cycle repeats. Because the counter runs both ways, each pulse sits centred on the same point of every period. The pulses are therefore symmetric and keep their phase as the duty cycle changes.

Each channel holds an active compare value. That value is refreshed from the channel's compare input only when the counter turns at its ceiling. When the counter lands on the active compare value, the channel sets or clears its output according to a 2-bit mode. The step direction decides which of the two. An external tick-enable input replaces a prescaler: the counter and outputs only move on cycles where it is high.

Top module: `pwm_dual_phase`

## Requirements
- R1: After reset the counter moves by exactly one per enabled tick. It rises until it reaches the ceiling, then falls until it reaches zero, and then rises again. Reset leaves it at 0, with `dir_down`=1 meaning the last step was downward, so the first tick goes to 1.
- R2: `res_sel` picks the ceiling: 2'b00 gives 255, 2'b01 gives 511, 2'b10 and 2'b11 give 1023. The full period is twice the ceiling in ticks (510, 1022, 2046).
- R3: In mode 2'b10 the output goes low when an upward step lands on the active compare value C and goes high when a downward step lands on C. With 0 < C < ceiling it is high for 2*C ticks of each period.
- R4: Mode 2'b11 swaps set and clear relative to 2'b10, giving 2*ceiling − 2*C high ticks per period.
- R5: Channels A and B share the counter but have separate compare values and modes, and neither affects the other.
- R6: With C equal to the ceiling, a mode-2'b10 output stays low for the whole period. With C equal to 0 it stays high for the whole period.
- R7: Modes 2'b00 and 2'b01 hold the output low.
- R8: A new compare input takes effect only from the tick on which the counter turns at the ceiling. Before that, matches use the previous value.
- R9: While `tick_en` is low, the counter, direction and outputs keep their values.
- R10: Reset clears both outputs and both active compare values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance enable (one timer tick) |
| res_sel | input | 2 | Resolution select |
| cmp_a | input | 10 | Compare value for channel A |
| cmp_b | input | 10 | Compare value for channel B |
| mode_a | input | 2 | Output mode for channel A |
| mode_b | input | 2 | Output mode for channel B |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| cnt | output | 10 | Current counter value |
| dir_down | output | 1 | 1 when the last step was downward |

## Verification
The step property assumes that `res_sel` changes only while reset is held, so the counter never sits above its ceiling. The stimulus sets the resolution before releasing reset in every scenario. The output-stability property assumes that a channel's mode changes only on cycles with no tick. Compare values are kept at or below the ceiling, and modes are written in the same cycle as reset. The bench models the active compare value itself, loading it at the turn at the ceiling, and checks every output sample against that model.

// File: rtl/pwm_dual_phase.sv
module pwm_dual_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] res_sel,
  input  logic [9:0] cmp_a,
  input  logic [9:0] cmp_b,
  input  logic [1:0] mode_a,
  input  logic [1:0] mode_b,
  output logic       out_a,
  output logic       out_b,
  output logic [9:0] cnt,
  output logic       dir_down
);
  logic [9:0] top, nxt, act_a, act_b;
  logic       at_top, at_bot, nxt_down, oc_a, oc_b;

  assign top      = res_sel[1] ? 10'h3FF : (res_sel[0] ? 10'h1FF : 10'h0FF);
  assign at_top   = !dir_down && (cnt >= top);
  assign at_bot   = dir_down && (cnt == 10'd0);
  assign nxt_down = at_top ? 1'b1 : (at_bot ? 1'b0 : dir_down);

  always_comb begin
    if (at_top)        nxt = top - 10'd1;
    else if (at_bot)   nxt = 10'd1;
    else if (dir_down) nxt = cnt - 10'd1;
    else               nxt = cnt + 10'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b1;
      act_a    <= '0;
      act_b    <= '0;
      oc_a     <= 1'b0;
      oc_b     <= 1'b0;
    end else if (tick_en) begin
      cnt      <= nxt;
      dir_down <= nxt_down;
      if (at_top) begin
        act_a <= cmp_a;
        act_b <= cmp_b;
      end
      if (mode_a[1] && nxt == act_a) oc_a <= nxt_down ? ~mode_a[0] : mode_a[0];
      if (mode_b[1] && nxt == act_b) oc_b <= nxt_down ? ~mode_b[0] : mode_b[0];
    end
  end

  assign out_a = mode_a[1] & oc_a;
  assign out_b = mode_b[1] & oc_b;
endmodule

module pwm_dual_phase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b,
  input logic       out_a,
  input logic       out_b,
  input logic [9:0] cnt,
  input logic       dir_down
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt) && $stable(dir_down)));

  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dir_down && cnt < 10'd255) |=> (cnt == $past(cnt) + 10'd1));

  p_turn_bot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt == 10'd0) |=> (cnt == 10'd1 && !dir_down));

  p_disc_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_a[1] |-> !out_a) and (!mode_b[1] |-> !out_b));

  p_out_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && $stable(mode_a) && $stable(mode_b)) |=>
      ($stable(out_a) && $stable(out_b)));
endmodule

bind pwm_dual_phase pwm_dual_phase_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_a(mode_a), .mode_b(mode_b),
  .out_a(out_a), .out_b(out_b), .cnt(cnt), .dir_down(dir_down)
);

// File: tb/test_pwm_dual_phase.sv
module test_pwm_dual_phase;
  logic clk = 0, rst_n = 0, tick_en = 0;
  logic [1:0] res_sel = 0, mode_a = 0, mode_b = 0;
  logic [9:0] cmp_a = 0, cmp_b = 0;
  logic out_a, out_b, dir_down;
  logic [9:0] cnt;

  int tests = 0, fails = 0;
  int m_cnt, m_act_a, m_act_b, n_cnt_err, n_a_err, n_b_err, hi_a, hi_b;
  bit m_dn;

  always #10 clk = ~clk;

  pwm_dual_phase i_pwm_dual_phase (.*);

  initial begin
    #3000000;
    tests++; fails++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int top_of(input logic [1:0] r);
    return r[1] ? 1023 : (r[0] ? 511 : 255);
  endfunction

  function automatic bit exp_out(input logic [1:0] m, input int c, input int q, input bit dn, input int t);
    bit b;
    if (!m[1]) return 0;
    if (c == 0) b = 1;
    else if (c >= t) b = 0;
    else b = dn ? (q <= c) : (q < c);
    return m[0] ? !b : b;
  endfunction

  task automatic clear_stats();
    n_cnt_err = 0; n_a_err = 0; n_b_err = 0; hi_a = 0; hi_b = 0;
  endtask

  task automatic step(input bit chk);
    int t;
    t = top_of(res_sel);
    @(posedge clk);
    if (tick_en) begin
      if (!m_dn && m_cnt >= t) begin
        m_act_a = cmp_a; m_act_b = cmp_b; m_cnt = t - 1; m_dn = 1;
      end else if (m_dn && m_cnt == 0) begin
        m_cnt = 1; m_dn = 0;
      end else if (m_dn) m_cnt--;
      else m_cnt++;
    end
    @(negedge clk);
    if (cnt !== m_cnt[9:0] || dir_down !== m_dn) n_cnt_err++;
    if (chk) begin
      if (out_a !== exp_out(mode_a, m_act_a, m_cnt, m_dn, t)) n_a_err++;
      if (out_b !== exp_out(mode_b, m_act_b, m_cnt, m_dn, t)) n_b_err++;
    end
    if (out_a === 1'b1) hi_a++;
    if (out_b === 1'b1) hi_b++;
  endtask

  task automatic do_reset(input logic [1:0] r, input logic [1:0] ma, input logic [9:0] ca,
                          input logic [1:0] mb, input logic [9:0] cb);
    @(negedge clk);
    rst_n = 0; tick_en = 1; res_sel = r;
    mode_a = ma; cmp_a = ca; mode_b = mb; cmp_b = cb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_dn = 1; m_act_a = 0; m_act_b = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0; mode_a = 2'b11; mode_b = 2'b11;
    repeat (2) @(negedge clk);
    check(cnt === 10'd0, "R1 reset count", cnt, 0);
    check(dir_down === 1'b1, "R1 reset direction", dir_down, 1);
    check(out_a === 1'b0 && out_b === 1'b0, "R10 reset outputs", {out_a, out_b}, 0);
  endtask

  task automatic t_period(input logic [1:0] r, input int per);
    int n = 0, mx = 0;
    do_reset(r, 2'b00, 0, 2'b00, 0);
    clear_stats();
    do begin
      step(0);
      n++;
      if (cnt > mx) mx = cnt;
    end while (cnt !== 10'd0 && n < 5000);
    check(n == per, "R2 period length", n, per);
    check(mx == top_of(r), "R2 ceiling", mx, top_of(r));
    check(n_cnt_err == 0, "R1 count sequence", n_cnt_err, 0);
  endtask

  task automatic t_duty(input logic [1:0] ma, input int ca, input logic [1:0] mb, input int cb,
                        input int ha, input int hb, input string req);
    do_reset(2'b00, ma, ca[9:0], mb, cb[9:0]);
    repeat (1020) step(0);
    clear_stats();
    repeat (510) step(1);
    check(n_a_err == 0, {req, " per-tick A"}, n_a_err, 0);
    check(n_b_err == 0, {req, " per-tick B"}, n_b_err, 0);
    check(hi_a == ha, {req, " high ticks A"}, hi_a, ha);
    check(hi_b == hb, {req, " high ticks B"}, hi_b, hb);
  endtask

  task automatic t_buffer();
    int guard = 0;
    do_reset(2'b00, 2'b10, 10'd50, 2'b10, 10'd50);
    repeat (1020) step(0);
    clear_stats();
    while (!(cnt == 10'd20 && !dir_down) && guard < 600) begin step(1); guard++; end
    cmp_a = 10'd200;
    while (!(cnt == 10'd100 && !dir_down) && guard < 1200) begin step(1); guard++; end
    check(out_a === 1'b0, "R8 old value holds before turn", out_a, 0);
    repeat (600) step(1);
    check(n_a_err == 0, "R8 load at ceiling", n_a_err, 0);
    clear_stats();
    repeat (510) step(1);
    check(hi_a == 400, "R8 new duty in effect", hi_a, 400);
  endtask

  task automatic t_hold();
    logic [9:0] c0;
    logic a0;
    do_reset(2'b00, 2'b10, 10'd30, 2'b00, 0);
    repeat (540) step(0);
    tick_en = 0;
    c0 = cnt; a0 = out_a;
    clear_stats();
    repeat (20) step(1);
    check(cnt === c0, "R9 count frozen", cnt, c0);
    check(out_a === a0, "R9 output frozen", out_a, a0);
    tick_en = 1;
    repeat (5) step(1);
    check(n_cnt_err == 0, "R9 resume", n_cnt_err, 0);
  endtask

  initial begin
    t_reset();
    t_period(2'b00, 510);
    t_period(2'b01, 1022);
    t_period(2'b10, 2046);
    t_duty(2'b10, 100, 2'b11, 100, 200, 310, "R3/R4");
    t_duty(2'b10, 40, 2'b10, 200, 80, 400, "R5");
    t_duty(2'b10, 255, 2'b10, 0, 0, 510, "R6");
    t_duty(2'b00, 100, 2'b01, 100, 0, 0, "R7");
    t_buffer();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule